// File: doc/BRIEF.md
# UART Host Bus Register Interface

This block sits between a small microcontroller bus and the serial engines of a UART. A host selects it with a chip select, a two-bit address and a direction line (1 = write, 0 = read). The block decodes each access into one of four registers: transmit data, receive data, status and control. It hands transmit bytes and read acknowledges to the serial engines. It returns their flags and received byte to the host.

The shared data bus is modelled as a read-data output and an output-enable. The enable is high only during a selected read, so an external tri-state driver can release the bus at all other times. The control register holds two interrupt enables, one per direction, and a three-bit rate-select field. The field goes straight to an external rate generator. A single interrupt request combines the enables with the status flags.

Top module: `uart_host_bus_if`

## Requirements
- R1: A selected read at address 00 drives `rx_data_i` on `rdata_o`, with `rdata_oe_o` high and `rx_read_o` high in that same cycle.
- R2: A selected write at address 00 loads `wdata_i` into `tx_data_o` at the clock edge. `tx_load_o` is then high for exactly the following cycle.
- R3: A selected read at address 01 returns status: bit 7 = `tx_empty_i`, bit 6 = `rx_full_i`, bit 5 = `overrun_i`, bits 4..0 = 0.
- R4: A selected write at address 01 is a no-op. The control register and `tx_data_o` keep their values, `tx_load_o` stays low and `rdata_oe_o` stays low.
- R5: A selected write at address 10 or 11 loads control: bit 7 = transmit interrupt enable, bit 6 = receive interrupt enable, bits 2..0 = rate select. A read at 10 or 11 returns those bits, with the other bits 0.
- R6: `rdata_oe_o` is high only during a selected read. While it is low, `rdata_o` is all zeros.
- R7: After reset the control register is 0, so both enables are off and the rate select is 0 (fastest rate). After reset `tx_data_o` is 0 and `tx_load_o` is low.
- R8: `irq_o` is high when the receive enable is set and either `rx_full_i` or `overrun_i` is 1.
- R9: `irq_o` is high when the transmit enable is set and `tx_empty_i` is 1. With neither condition of R8 or R9 true, `irq_o` is low.
- R10: When `cs_i` is low, no register changes, `tx_load_o` and `rx_read_o` stay low and the bus is not driven.
- R11: `baud_sel_o` always equals the stored rate-select field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data toward the bus driver |
| rdata_oe_o | output | 1 | Bus driver enable |
| tx_data_o | output | 8 | Byte for the transmit engine |
| tx_load_o | output | 1 | One-cycle strobe: new transmit byte |
| rx_data_i | input | 8 | Byte from the receive engine |
| rx_read_o | output | 1 | Receive data read acknowledge |
| tx_empty_i | input | 1 | Transmit register empty flag |
| rx_full_i | input | 1 | Receive register full flag |
| overrun_i | input | 1 | Receive overrun flag |
| baud_sel_o | output | 3 | Rate select to the rate generator |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted control register shows at the ports at once. `baud_sel_o` changes on the next cycle, `irq_o` stops following the flags, and the next control read returns the wrong bits. A wrong decode shows in the same cycle as the access: the bus is driven during a write, a read is muxed from the wrong source, or the status padding bits are non-zero. A transmit write that is lost or duplicated shows one cycle after the access, on `tx_load_o` and `tx_data_o`. The random mix of accesses and flags reaches each of these paths many times.

// File: rtl/uart_hbi_pkg.sv
package uart_hbi_pkg;
  parameter int DATA_W = 8;
  parameter int BAUD_W = 3;

  localparam int STAT_TXE_BIT = DATA_W - 1;
  localparam int STAT_RXF_BIT = DATA_W - 2;
  localparam int STAT_OVR_BIT = DATA_W - 3;
  localparam int CTRL_TIE_BIT = DATA_W - 1;
  localparam int CTRL_RIE_BIT = DATA_W - 2;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_RD_RX,
    ACC_WR_TX,
    ACC_RD_STAT,
    ACC_WR_NOP,
    ACC_RD_CTRL,
    ACC_WR_CTRL
  } acc_e;

  typedef struct packed {
    logic              tx_ie;
    logic              rx_ie;
    logic [BAUD_W-1:0] baud;
  } ctrl_t;
endpackage

// File: rtl/hbi_decode.sv
module hbi_decode
  import uart_hbi_pkg::*;
(
  input  logic       cs_i,
  input  logic       wr_i,
  input  logic [1:0] addr_i,
  output acc_e       acc_o
);
  always_comb begin
    acc_o = ACC_IDLE;
    if (cs_i) begin
      unique casez ({addr_i, wr_i})
        3'b00_0: acc_o = ACC_RD_RX;
        3'b00_1: acc_o = ACC_WR_TX;
        3'b01_0: acc_o = ACC_RD_STAT;
        3'b01_1: acc_o = ACC_WR_NOP;
        3'b1?_0: acc_o = ACC_RD_CTRL;
        3'b1?_1: acc_o = ACC_WR_CTRL;
        default: acc_o = ACC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hbi_regs.sv
module hbi_regs
  import uart_hbi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_e              acc_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_load_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      tx_data_o <= '0;
      tx_load_o <= 1'b0;
    end else begin
      tx_load_o <= (acc_i == ACC_WR_TX);
      if (acc_i == ACC_WR_TX) tx_data_o <= wdata_i;
      if (acc_i == ACC_WR_CTRL) begin
        ctrl_q.tx_ie <= wdata_i[CTRL_TIE_BIT];
        ctrl_q.rx_ie <= wdata_i[CTRL_RIE_BIT];
        ctrl_q.baud  <= wdata_i[BAUD_W-1:0];
      end
    end
  end

  assign ctrl_o = ctrl_q;

  assert_nop_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_WR_NOP) |=> ($stable(ctrl_q) && $stable(tx_data_o) && !tx_load_o));
  assert_tx_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_WR_TX) |=> (tx_load_o && tx_data_o == $past(wdata_i)));
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_IDLE) |=> ($stable(ctrl_q) && !tx_load_o));
endmodule

// File: rtl/hbi_rdmux.sv
module hbi_rdmux
  import uart_hbi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_e              acc_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              tx_empty_i,
  input  logic              rx_full_i,
  input  logic              overrun_i,
  input  ctrl_t             ctrl_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              rx_read_o
);
  logic [DATA_W-1:0] stat_w, ctrl_w;

  always_comb begin
    stat_w = '0;
    stat_w[STAT_TXE_BIT] = tx_empty_i;
    stat_w[STAT_RXF_BIT] = rx_full_i;
    stat_w[STAT_OVR_BIT] = overrun_i;
    ctrl_w = '0;
    ctrl_w[CTRL_TIE_BIT] = ctrl_i.tx_ie;
    ctrl_w[CTRL_RIE_BIT] = ctrl_i.rx_ie;
    ctrl_w[BAUD_W-1:0]   = ctrl_i.baud;
  end

  always_comb begin
    rdata_o    = '0;
    rdata_oe_o = 1'b1;
    unique case (acc_i)
      ACC_RD_RX:   rdata_o = rx_data_i;
      ACC_RD_STAT: rdata_o = stat_w;
      ACC_RD_CTRL: rdata_o = ctrl_w;
      default:     rdata_oe_o = 1'b0;
    endcase
  end

  assign rx_read_o = (acc_i == ACC_RD_RX);

  assert_stat_pad_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_RD_STAT) |-> (rdata_o[STAT_OVR_BIT-1:0] == '0));
  assert_quiet_bus_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_oe_o |-> (rdata_o == '0 && !rx_read_o));
endmodule

// File: rtl/hbi_irq.sv
module hbi_irq
  import uart_hbi_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  input  logic  tx_empty_i,
  input  logic  rx_full_i,
  input  logic  overrun_i,
  output logic  irq_o
);
  logic rx_req, tx_req;
  assign rx_req = ctrl_i.rx_ie & (rx_full_i | overrun_i);
  assign tx_req = ctrl_i.tx_ie & tx_empty_i;
  assign irq_o  = rx_req | tx_req;

  assert_rx_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.rx_ie && overrun_i) |-> irq_o);
  assert_tx_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.tx_ie && !ctrl_i.rx_ie) |-> !irq_o);
endmodule

// File: rtl/uart_host_bus_if.sv
module uart_host_bus_if
  import uart_hbi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_load_o,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_read_o,
  input  logic              tx_empty_i,
  input  logic              rx_full_i,
  input  logic              overrun_i,
  output logic [BAUD_W-1:0] baud_sel_o,
  output logic              irq_o
);
  acc_e  acc;
  ctrl_t ctrl;

  hbi_decode u_dec (.cs_i(cs_i), .wr_i(wr_i), .addr_i(addr_i), .acc_o(acc));

  hbi_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .wdata_i(wdata_i),
    .ctrl_o(ctrl), .tx_data_o(tx_data_o), .tx_load_o(tx_load_o)
  );

  hbi_rdmux u_mux (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .rx_data_i(rx_data_i),
    .tx_empty_i(tx_empty_i), .rx_full_i(rx_full_i), .overrun_i(overrun_i),
    .ctrl_i(ctrl), .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o), .rx_read_o(rx_read_o)
  );

  hbi_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl), .tx_empty_i(tx_empty_i),
    .rx_full_i(rx_full_i), .overrun_i(overrun_i), .irq_o(irq_o)
  );

  assign baud_sel_o = ctrl.baud;

  assert_oe_on_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !wr_i) |-> rdata_oe_o);
  assert_oe_not_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i || !cs_i) |-> !rdata_oe_o);
endmodule

// File: tb/uart_host_bus_if_tb_top.sv
module uart_host_bus_if_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rx_data = '0;
  logic       txe = 1'b0, rxf = 1'b0, ovr = 1'b0;
  logic [7:0] rdata, tx_data;
  logic       oe, tx_load, rx_read, irq;
  logic [2:0] baud;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // host-visible model
  logic       m_tie = 0, m_rie = 0;
  logic [2:0] m_baud = 0;
  logic [7:0] m_tx = 0;
  logic       m_load = 0;

  always #4 clk = ~clk;

  uart_host_bus_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(oe), .tx_data_o(tx_data),
    .tx_load_o(tx_load), .rx_data_i(rx_data), .rx_read_o(rx_read),
    .tx_empty_i(txe), .rx_full_i(rxf), .overrun_i(ovr), .baud_sel_o(baud),
    .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rdata();
    if (!cs || wr) return 8'h00;
    case (addr)
      2'b00:   return rx_data;
      2'b01:   return {txe, rxf, ovr, 5'b0};
      default: return {m_tie, m_rie, 3'b0, m_baud};
    endcase
  endfunction

  function automatic logic exp_irq();
    return (m_rie && (rxf || ovr)) || (m_tie && txe);
  endfunction

  // drive at negedge, check combinational just before posedge, registered after it
  task automatic cycle(input logic c, input logic w, input logic [1:0] a, input logic [7:0] d,
                       input logic [7:0] rx, input logic e, input logic f, input logic o);
    @(negedge clk);
    cs = c; wr = w; addr = a; wdata = d; rx_data = rx; txe = e; rxf = f; ovr = o;
    #2;
    chk(rdata == exp_rdata(), (a == 2'b01) ? "R3" : (a == 2'b00 ? "R1" : "R5"), rdata, exp_rdata());
    chk(oe == (c && !w), "R6", oe, c && !w);
    chk(rx_read == (c && !w && a == 2'b00), "R1", rx_read, c && !w && a == 2'b00);
    chk(irq == exp_irq(), "R8_R9", irq, exp_irq());
    @(posedge clk);
    m_load = c && w && a == 2'b00;
    if (m_load) m_tx = d;
    if (c && w && a[1]) begin m_tie = d[7]; m_rie = d[6]; m_baud = d[2:0]; end
    #1;
    chk(tx_load == m_load, "R2", tx_load, m_load);
    chk(tx_data == m_tx, "R2_R4", tx_data, m_tx);
    chk(baud == m_baud, "R11", baud, m_baud);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #20;
    // R7 reset state
    chk(baud == 3'd0, "R7", baud, 0);
    chk(tx_data == 8'h00 && !tx_load, "R7", tx_data, 0);
    chk(!oe && rdata == 0, "R7", oe, 0);
    rst_n = 1'b1;
    // directed: R5 control write then read
    cycle(1, 1, 2'b10, 8'hC5, 8'h00, 1, 0, 0);
    cycle(1, 0, 2'b11, 8'h00, 8'h00, 1, 0, 0); // R9 irq via tx
    // R4: write to status address changes nothing
    cycle(1, 1, 2'b01, 8'h3A, 8'h00, 0, 0, 0);
    cycle(1, 0, 2'b10, 8'h00, 8'h00, 0, 0, 0);
    // R2 back-to-back transmit writes
    cycle(1, 1, 2'b00, 8'hA5, 8'h00, 0, 0, 0);
    cycle(1, 1, 2'b00, 8'h5A, 8'h00, 0, 0, 0);
    cycle(0, 1, 2'b00, 8'hFF, 8'h00, 0, 0, 0); // R10 no select
    cycle(0, 1, 2'b11, 8'h00, 8'h00, 0, 0, 0); // R10 control unchanged
    // R8 overrun alone with rx enable
    cycle(1, 1, 2'b10, 8'h40, 8'h00, 0, 0, 1);
    cycle(1, 0, 2'b00, 8'h00, 8'h99, 0, 0, 1); // R1
    cycle(1, 0, 2'b01, 8'h00, 8'h00, 1, 1, 1); // R3 all flags
    // random mix
    for (int i = 0; i < 3000; i++) begin
      cycle($urandom_range(0, 3) != 0, $urandom_range(0, 1), 2'($urandom), 8'($urandom),
            8'($urandom), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
    end
    // reset in mid-run returns control to defaults (R7)
    @(negedge clk); rst_n = 1'b0; cs = 0; #1;
    chk(baud == 0 && !irq, "R7", baud, 0);
    m_tie = 0; m_rie = 0; m_baud = 0; m_tx = 0;
    @(negedge clk); rst_n = 1'b1;
    cycle(1, 0, 2'b10, 8'h00, 8'h00, 1, 1, 1);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule